// File: doc/BRIEF.md
# Maskable Vectored Interrupt Unit

This unit sits between a set of level-sensitive device request lines and the control sequencer of a small processor core. It owns the processor status register, whose bit 0 is the global interrupt enable, and a mask register with one enable bit per request line. At every instruction boundary that the core signals, the unit considers the requests that are both asserted and unmasked. If the global enable is set, it takes the most urgent one.

Taking a request is a single-cycle event. The unit raises a take strobe and presents a vector number (0x08 plus the line index). In the same edge it captures the core's current PC and the live status into shadow registers, and it clears the enable bit in the live status so that no second request is taken while the handler runs. A return pulse copies the shadow status back into the live status. The shadow PC is always visible on an output, so the core can resume the interrupted program from it. The core may also load the whole status register, and it has dedicated pulses that set or clear the enable bit alone.

Top module: `vec_irq_unit`

## Requirements
- R1: After reset the live status, shadow status and shadow PC are all zero, the mask is all zeros (every line masked), and no take strobe is raised.
- R2: A set-enable pulse forces status bit 0 to 1 and a clear-enable pulse forces it to 0, leaving bits 7..1 unchanged; when both pulses arrive in the same cycle, clear wins.
- R3: A status write loads the whole status register from the status input; a set-enable or clear-enable pulse in the same cycle is then applied on top of the written value.
- R4: No request is taken while status bit 0 is 0, even if an asserted, unmasked line exists at a boundary.
- R5: A line whose mask bit is 0 is never taken; the mask is loaded whole by a mask write, with bit i governing line i.
- R6: A request is taken only in a cycle in which the boundary strobe is 1; the take strobe and vector are combinational in that cycle.
- R7: Among pending unmasked lines, the lowest index wins, and the vector equals 0x08 plus that index (line 1 gives 0x09, line 7 gives 0x0F).
- R8: In the cycle after a take, the shadow PC equals the PC presented in the take cycle, the shadow status equals the status before the take, and the live status equals the old status with bit 0 cleared.
- R9: The take strobe lasts exactly one cycle, even when the boundary strobe and the request stay high.
- R10: A return pulse makes the live status equal to the shadow status in the next cycle, overriding any status write, set-enable or clear-enable in that cycle. The returned-PC output always shows the shadow PC.
- R11: The shadow PC and shadow status change only on the edge that ends a take cycle.
- R12: A request that is still held after a return is taken again at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | 8 | Level-sensitive request lines, line 0 most urgent |
| boundary | input | 1 | Core is at an instruction boundary |
| setEn | input | 1 | Pulse: set global enable (status bit 0) |
| clrEn | input | 1 | Pulse: clear global enable (status bit 0) |
| statusWe | input | 1 | Load the whole status register |
| statusIn | input | 8 | Status value to load |
| maskWe | input | 1 | Load the per-line mask register |
| maskIn | input | 8 | Mask value, 1 enables the line |
| retPulse | input | 1 | Return from handler: restore status |
| curPc | input | 16 | PC of the next instruction, captured on take |
| takeIrq | output | 1 | One-cycle take strobe |
| vecNum | output | 8 | Vector number, valid while takeIrq is 1 |
| statusOut | output | 8 | Live status register |
| retPc | output | 16 | Shadow PC for resuming after return |
| retStatus | output | 8 | Shadow status |

## Verification
The assertions assume the core never raises a return pulse in the same cycle as a take. They also assume that an instruction boundary that starts a handler is not the same cycle in which software re-enables interrupts. Under these assumptions the one-cycle take and the restore relation are well defined. The directed stimulus follows this discipline. Returns are issued only while a handler is active and the boundary strobe is low. Enable pulses and status writes are placed in cycles with no boundary, so every take sees a status that was settled on the previous edge.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  // strobes from the control module to the datapath
  typedef struct packed {
    logic take;
    logic restore;
    logic statLoad;
    logic enSet;
    logic enClr;
    logic maskLoad;
  } irqStrobes_t;
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_unit_pkg::*;
#(
  parameter int N_LINES  = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 8
) (
  input  logic [N_LINES-1:0] irqReq,
  input  logic [N_LINES-1:0] maskBits,
  input  logic               enBit,
  input  logic               boundary,
  input  logic               setEn,
  input  logic               clrEn,
  input  logic               statusWe,
  input  logic               maskWe,
  input  logic               retPulse,
  output irqStrobes_t        strobes,
  output logic [VEC_W-1:0]   vecNum
);
  localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

  logic [N_LINES-1:0] pending;
  logic               anyPending;
  logic [IDX_W-1:0]   pickIdx;

  assign pending    = irqReq & maskBits;
  assign anyPending = |pending;

  // lowest index has the highest priority: scan downward, last hit wins
  always_comb begin
    pickIdx = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (pending[i]) pickIdx = IDX_W'(i);
    end
  end

  assign vecNum = VEC_W'(VEC_BASE) + VEC_W'(pickIdx);

  always_comb begin
    strobes.take     = boundary & enBit & anyPending;
    strobes.restore  = retPulse & ~strobes.take;
    strobes.statLoad = statusWe;
    strobes.enSet    = setEn;
    strobes.enClr    = clrEn;
    strobes.maskLoad = maskWe;
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_unit_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int PC_W    = 16,
  parameter int STAT_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  irqStrobes_t        strobes,
  input  logic [STAT_W-1:0]  statusIn,
  input  logic [N_LINES-1:0] maskIn,
  input  logic [PC_W-1:0]    curPc,
  output logic [STAT_W-1:0]  statusReg,
  output logic [N_LINES-1:0] maskReg,
  output logic [PC_W-1:0]    savedPc,
  output logic [STAT_W-1:0]  savedStatus
);
  localparam int EN_BIT = 0;

  logic [STAT_W-1:0] statusNext;

  // ordinary status update: optional full load, then enable bit override
  always_comb begin
    statusNext = strobes.statLoad ? statusIn : statusReg;
    if (strobes.enClr)      statusNext[EN_BIT] = 1'b0;
    else if (strobes.enSet) statusNext[EN_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusReg   <= '0;
      savedPc     <= '0;
      savedStatus <= '0;
    end else if (strobes.take) begin
      savedPc             <= curPc;
      savedStatus         <= statusReg;
      statusReg[EN_BIT]   <= 1'b0;
    end else if (strobes.restore) begin
      statusReg <= savedStatus;
    end else begin
      statusReg <= statusNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 maskReg <= '0;
    else if (strobes.maskLoad) maskReg <= maskIn;
  end
endmodule

// File: rtl/vec_irq_unit.sv
module vec_irq_unit
  import irq_unit_pkg::*;
#(
  parameter int N_LINES  = 8,
  parameter int PC_W     = 16,
  parameter int STAT_W   = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [N_LINES-1:0] irqReq,
  input  logic               boundary,
  input  logic               setEn,
  input  logic               clrEn,
  input  logic               statusWe,
  input  logic [STAT_W-1:0]  statusIn,
  input  logic               maskWe,
  input  logic [N_LINES-1:0] maskIn,
  input  logic               retPulse,
  input  logic [PC_W-1:0]    curPc,
  output logic               takeIrq,
  output logic [VEC_W-1:0]   vecNum,
  output logic [STAT_W-1:0]  statusOut,
  output logic [PC_W-1:0]    retPc,
  output logic [STAT_W-1:0]  retStatus
);
  irqStrobes_t        strobes;
  logic [N_LINES-1:0] maskBits;
  logic [STAT_W-1:0]  statusReg;

  irq_ctrl #(.N_LINES(N_LINES), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_ctrl (
    .irqReq   (irqReq),
    .maskBits (maskBits),
    .enBit    (statusReg[0]),
    .boundary (boundary),
    .setEn    (setEn),
    .clrEn    (clrEn),
    .statusWe (statusWe),
    .maskWe   (maskWe),
    .retPulse (retPulse),
    .strobes  (strobes),
    .vecNum   (vecNum)
  );

  irq_datapath #(.N_LINES(N_LINES), .PC_W(PC_W), .STAT_W(STAT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .statusIn    (statusIn),
    .maskIn      (maskIn),
    .curPc       (curPc),
    .statusReg   (statusReg),
    .maskReg     (maskBits),
    .savedPc     (retPc),
    .savedStatus (retStatus)
  );

  assign takeIrq   = strobes.take;
  assign statusOut = statusReg;
endmodule

// File: rtl/irq_unit_chk.sv
module irq_unit_chk #(
  parameter int N_LINES  = 8,
  parameter int PC_W     = 16,
  parameter int STAT_W   = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [N_LINES-1:0] irqReq,
  input logic [N_LINES-1:0] maskBits,
  input logic               boundary,
  input logic               retPulse,
  input logic               takeIrq,
  input logic [VEC_W-1:0]   vecNum,
  input logic [STAT_W-1:0]  statusOut,
  input logic [PC_W-1:0]    retPc,
  input logic [STAT_W-1:0]  retStatus
);
  // R4
  take_needs_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> statusOut[0]);

  // R5
  take_needs_unmasked_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> (|(irqReq & maskBits)));

  // R6
  take_on_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> boundary);

  // R7
  vec_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> (vecNum >= VEC_W'(VEC_BASE)) && (vecNum < VEC_W'(VEC_BASE + N_LINES)));

  // R8
  take_clears_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |=> !statusOut[0]);

  // R9
  one_shot_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |=> !takeIrq);

  // R10
  restore_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retPulse && !takeIrq) |=> (statusOut == $past(retStatus)));

  // R11
  shadow_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !takeIrq |=> ($stable(retPc) && $stable(retStatus)));
endmodule

bind vec_irq_unit irq_unit_chk #(
  .N_LINES(N_LINES), .PC_W(PC_W), .STAT_W(STAT_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .irqReq    (irqReq),
  .maskBits  (maskBits),
  .boundary  (boundary),
  .retPulse  (retPulse),
  .takeIrq   (takeIrq),
  .vecNum    (vecNum),
  .statusOut (statusOut),
  .retPc     (retPc),
  .retStatus (retStatus)
);

// File: tb/tb_vec_irq_unit.sv
`timescale 1ns/1ps
module tb_vec_irq_unit;
  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  irqReq;
  logic        boundary, setEn, clrEn, statusWe, maskWe, retPulse;
  logic [7:0]  statusIn, maskIn;
  logic [15:0] curPc;
  logic        takeIrq;
  logic [7:0]  vecNum, statusOut, retStatus;
  logic [15:0] retPc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vec_irq_unit dut (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .boundary(boundary),
    .setEn(setEn), .clrEn(clrEn), .statusWe(statusWe), .statusIn(statusIn),
    .maskWe(maskWe), .maskIn(maskIn), .retPulse(retPulse), .curPc(curPc),
    .takeIrq(takeIrq), .vecNum(vecNum), .statusOut(statusOut),
    .retPc(retPc), .retStatus(retStatus)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    boundary = 0; setEn = 0; clrEn = 0; statusWe = 0; maskWe = 0; retPulse = 0;
  endtask

  // one cycle: drive at negedge, let it settle, caller checks, then next negedge
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic writeStatus(input logic [7:0] v);
    @(negedge clk); idle(); statusWe = 1; statusIn = v;
    @(negedge clk); idle();
  endtask

  task automatic writeMask(input logic [7:0] v);
    @(negedge clk); idle(); maskWe = 1; maskIn = v;
    @(negedge clk); idle();
  endtask

  task automatic doReturn();
    @(negedge clk); idle(); retPulse = 1;
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    rstN = 0; idle(); irqReq = 0; statusIn = 0; maskIn = 0; curPc = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk); #1;
    chk("R1 status", statusOut, 8'h00);
    chk("R1 retStatus", retStatus, 8'h00);
    chk("R1 retPc", retPc, 16'h0000);
    chk("R1 take", takeIrq, 1'b0);
  endtask

  task automatic t_enable_ops();
    @(negedge clk); idle(); setEn = 1;
    @(negedge clk); idle(); #1;
    chk("R2 setEn", statusOut, 8'h01);
    writeStatus(8'hA4); #1;
    chk("R3 status load", statusOut, 8'hA4);
    @(negedge clk); idle(); setEn = 1;
    @(negedge clk); idle(); #1;
    chk("R2 setEn keeps upper", statusOut, 8'hA5);
    @(negedge clk); idle(); clrEn = 1;
    @(negedge clk); idle(); #1;
    chk("R2 clrEn", statusOut, 8'hA4);
    @(negedge clk); idle(); setEn = 1; clrEn = 1;
    @(negedge clk); idle(); #1;
    chk("R2 clr wins", statusOut, 8'hA4);
    @(negedge clk); idle(); statusWe = 1; statusIn = 8'h30; setEn = 1;
    @(negedge clk); idle(); #1;
    chk("R3 load plus setEn", statusOut, 8'h31);
    @(negedge clk); idle(); statusWe = 1; statusIn = 8'hFF; clrEn = 1;
    @(negedge clk); idle(); #1;
    chk("R3 load plus clrEn", statusOut, 8'hFE);
  endtask

  task automatic t_masked_by_reset();
    writeStatus(8'h01);
    @(negedge clk); idle(); irqReq = 8'hFF; boundary = 1; #1;
    chk("R5 reset mask blocks", takeIrq, 1'b0);
    @(negedge clk); idle(); #1;
    chk("R5 status untouched", statusOut, 8'h01);
    irqReq = 0;
  endtask

  task automatic t_disabled();
    writeMask(8'hFF);
    writeStatus(8'h00);
    @(negedge clk); idle(); irqReq = 8'h01; boundary = 1; #1;
    chk("R4 disabled no take", takeIrq, 1'b0);
    @(negedge clk); idle(); irqReq = 0;
  endtask

  task automatic t_no_boundary();
    writeStatus(8'h01);
    @(negedge clk); idle(); irqReq = 8'h04; #1;
    chk("R6 no boundary", takeIrq, 1'b0);
    @(negedge clk); idle(); #1;
    chk("R6 enable kept", statusOut, 8'h01);
    irqReq = 0;
  endtask

  task automatic takeOnce(input logic [7:0] req, input logic [7:0] expVec, input string tag);
    writeStatus(8'h01);
    @(negedge clk); idle(); irqReq = req; boundary = 1; curPc = 16'h0100; #1;
    chk({tag, " take"}, takeIrq, 1'b1);
    chk({tag, " vector"}, vecNum, expVec);
    @(negedge clk); idle(); irqReq = 0;
    doReturn();
  endtask

  task automatic t_priority();
    takeOnce(8'h06, 8'h09, "R7 lines 1,2");
    takeOnce(8'h80, 8'h0F, "R7 line 7");
    takeOnce(8'hA8, 8'h0B, "R7 lines 3,5,7");
    writeMask(8'hFE);
    takeOnce(8'h81, 8'h0F, "R5 line0 masked");
    writeMask(8'hFF);
  endtask

  task automatic t_entry_return();
    writeStatus(8'h5B);
    @(negedge clk); idle(); irqReq = 8'h02; boundary = 1; curPc = 16'h1234; #1;
    chk("R8 take", takeIrq, 1'b1);
    @(negedge clk); idle(); irqReq = 8'h02; boundary = 1; curPc = 16'h4444; #1;
    chk("R9 one cycle", takeIrq, 1'b0);
    chk("R8 live status", statusOut, 8'h5A);
    chk("R8 saved pc", retPc, 16'h1234);
    chk("R8 saved status", retStatus, 8'h5B);
    @(negedge clk); idle(); #1;
    chk("R11 saved pc held", retPc, 16'h1234);
    chk("R11 saved status held", retStatus, 8'h5B);
    writeStatus(8'h20); #1;
    chk("R11 after status write", retStatus, 8'h5B);
    @(negedge clk); idle(); retPulse = 1; statusWe = 1; statusIn = 8'h77; setEn = 1;
    @(negedge clk); idle(); #1;
    chk("R10 restored status", statusOut, 8'h5B);
    chk("R10 retPc", retPc, 16'h1234);
    curPc = 16'h2000; boundary = 1; #1;
    chk("R12 level retake", takeIrq, 1'b1);
    chk("R12 vector", vecNum, 8'h09);
    @(negedge clk); idle(); irqReq = 0; #1;
    chk("R12 saved pc", retPc, 16'h2000);
  endtask

  initial begin
    t_reset();
    t_enable_ops();
    t_masked_by_reset();
    t_disabled();
    t_no_boundary();
    t_priority();
    t_entry_return();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule